// File: doc/BRIEF.md
# Edge-Sensed GPIO Interrupt Controller

This block monitors a bank of general-purpose input lines and turns selected transitions on them into an interrupt request for a host processor. Each line passes through a two-flop synchroniser. A per-line two-bit code selects which transitions count on that line: none, low-to-high, high-to-low, or both. Every detected transition is recorded in an event status register. When the line is unmasked, the transition is also recorded in an interrupt source register. The shared interrupt request is active low and is meant to drive an open-drain pad: a 0 turns the pull-down on, and a 1 releases the line.

The host uses a plain synchronous register port. It can program the mask and the sensitivity codes, read the status and source registers, and acknowledge events by writing ones to the status register. Any change to a line's sensitivity code discards that line's pending event, so a reconfiguration never leaves a stale interrupt behind.

Top module: `gei_irq_ctrl`

## Requirements
- R1: After a synchronous reset the mask register reads all ones and both sensitivity registers read zero. Status and source read zero, and `irq_n` is 1.
- R2: Line k has a two-bit sensitivity code. Lines 0 to LINES/2-1 use bits 2k+1:2k of the low sensitivity register (address 1). The remaining lines use bits 2j+1:2j of the high register (address 2), where j = k-LINES/2. The codes are: 00 = no edge, 01 = rising, 10 = falling, 11 = either edge.
- R3: Writing a 1 to a bit of the status register (address 3) clears that status bit and the matching source bit. Bits written as 0 are unchanged.
- R4: `irq_n` is 0 while any source bit is set and 1 when none is set.
- R5: A qualifying edge on a line whose mask bit (address 0) is 0 sets its source bit. A mask bit of 1 keeps the source bit clear.
- R6: A qualifying edge sets the line's status bit whatever its mask bit is.
- R7: A write that changes a line's sensitivity code clears that line's status and source bits. Rewriting the same code, or changing the code of another line, leaves them unchanged.
- R8: When a qualifying edge and a status clear for the same line fall in the same cycle, the bit ends up set.
- R9: A pin transition is seen at the third rising clock edge after it. Status, source and `irq_n` all update on that edge.
- R10: `rd_data` shows the register selected by `rd_addr` one clock later. The addresses are 0 mask, 1 low sensitivity, 2 high sensitivity, 3 status and 4 source. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | LINES | Asynchronous GPIO input levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | LINES | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | LINES | Registered read data |
| irq_n | output | 1 | Active-low interrupt request (low = pull pad down) |

## Verification
A pin change is due in status, source and `irq_n` at the third rising edge after the change. A register write takes effect at the edge that captures it. A read returns its value one edge after `rd_addr` is set. The bench changes pins and write strobes just after falling edges. It then counts rising edges to the one where the result is due and samples at the following falling edge. The latency test samples `irq_n` after the first, second and third edges. The same-cycle test places the clear write exactly on the third edge after a pin change.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_ANY  = 2'b11
  } sense_e;

  localparam logic [ADDR_W-1:0] A_MASK     = 3'd0;
  localparam logic [ADDR_W-1:0] A_SENSE_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_SENSE_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SOURCE   = 3'd4;
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gei_edge.sv
module gei_edge
  import gei_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINES-1:0]   level,
  input  logic [2*LINES-1:0] sense,
  output logic [LINES-1:0]   hit
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic up, down;
    assign up   = level[k] & ~prev_q[k];
    assign down = ~level[k] & prev_q[k];
    always_comb begin
      unique case (sense_e'(sense[2*k +: 2]))
        SENSE_RISE: hit[k] = up;
        SENSE_FALL: hit[k] = down;
        SENSE_ANY:  hit[k] = up | down;
        default:    hit[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gei_status.sv
module gei_status #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] hit,
  input  logic [LINES-1:0] clr,
  input  logic [LINES-1:0] mask,
  output logic [LINES-1:0] status_q,
  output logic [LINES-1:0] source_q,
  output logic             irq_n
);
  logic [LINES-1:0] status_d, source_d;

  // a new edge outranks a clear in the same cycle
  assign status_d = hit | (status_q & ~clr);
  assign source_d = (hit & ~mask) | (source_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      source_q <= '0;
      irq_n    <= 1'b1;
    end else begin
      status_q <= status_d;
      source_q <= source_d;
      irq_n    <= ~|source_d;
    end
  end
endmodule

// File: rtl/gei_irq_ctrl.sv
module gei_irq_ctrl
  import gei_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LINES-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LINES-1:0]  rd_data,
  output logic              irq_n
);
  localparam int SW = 2 * LINES;

  logic [LINES-1:0] level;
  logic [LINES-1:0] hit;
  logic [LINES-1:0] mask_q;
  logic [SW-1:0]    sense_q, sense_d;
  logic [LINES-1:0] chg, clr;
  logic [LINES-1:0] status_q, source_q;

  gei_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(level)
  );

  gei_edge #(.LINES(LINES)) u_edge (
    .clk(clk), .rst(rst), .level(level), .sense(sense_q), .hit(hit)
  );

  always_comb begin
    sense_d = sense_q;
    if (wr_en && wr_addr == A_SENSE_LO) sense_d[LINES-1:0]  = wr_data;
    if (wr_en && wr_addr == A_SENSE_HI) sense_d[SW-1:LINES] = wr_data;
  end

  for (genvar k = 0; k < LINES; k++) begin : g_chg
    assign chg[k] = sense_d[2*k +: 2] != sense_q[2*k +: 2];
  end

  assign clr = chg | ((wr_en && wr_addr == A_STATUS) ? wr_data : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      sense_q <= '0;
    end else begin
      sense_q <= sense_d;
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data;
    end
  end

  gei_status #(.LINES(LINES)) u_status (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .mask(mask_q),
    .status_q(status_q), .source_q(source_q), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_addr)
        A_MASK:     rd_data <= mask_q;
        A_SENSE_LO: rd_data <= sense_q[LINES-1:0];
        A_SENSE_HI: rd_data <= sense_q[SW-1:LINES];
        A_STATUS:   rd_data <= status_q;
        A_SOURCE:   rd_data <= source_q;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gei_irq_checker.sv
module gei_irq_checker #(
  parameter int LINES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_n,
  input logic [LINES-1:0]   mask_q,
  input logic [2*LINES-1:0] sense_q,
  input logic [LINES-1:0]   status_q,
  input logic [LINES-1:0]   source_q
);
  logic [LINES-1:0] off_vec;
  for (genvar k = 0; k < LINES; k++) begin : g_off
    assign off_vec[k] = sense_q[2*k +: 2] == 2'b00;
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && irq_n && status_q == '0 && source_q == '0 && sense_q == '0));

  a_r4_irq_tracks_source: assert property (@(posedge clk) disable iff (rst)
    irq_n == ~|source_q);

  a_r5_masked_no_source: assert property (@(posedge clk) disable iff (rst)
    ((source_q & ~$past(source_q)) & $past(mask_q)) == '0);

  a_r6_source_within_status: assert property (@(posedge clk) disable iff (rst)
    (source_q & ~status_q) == '0);

  a_r2_off_never_sets: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q)) & $past(off_vec)) == '0);
endmodule

bind gei_irq_ctrl gei_irq_checker #(.LINES(LINES)) u_gei_chk (
  .clk(clk), .rst(rst), .irq_n(irq_n), .mask_q(mask_q), .sense_q(sense_q),
  .status_q(status_q), .source_q(source_q)
);

// File: tb/test_gei_irq_ctrl.sv
`timescale 1ns/1ps
module test_gei_irq_ctrl;
  localparam int LINES = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LINES-1:0] pins = '0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [LINES-1:0] wr_data = '0;
  logic [2:0]       rd_addr = '0;
  logic [LINES-1:0] rd_data;
  logic             irq_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gei_irq_ctrl #(.LINES(LINES)) i_gei_irq_ctrl (
    .clk(clk), .rst(rst), .pin_in(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  // {code[4:3], from[2], to[1], expected status[0]} for line 0
  localparam logic [4:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b1, 1'b0}, {2'b00, 1'b1, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1}, {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b0}, {2'b10, 1'b1, 1'b0, 1'b1},
    {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [LINES-1:0] got, input logic [LINES-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [LINES-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [LINES-1:0] v);
    @(negedge clk); rd_addr = a;
    @(posedge clk);
    @(negedge clk); v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [LINES-1:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    rd(3'd0, v); check("R1 mask", v, 8'hFF);
    rd(3'd1, v); check("R1 sense lo", v, 8'h00);
    rd(3'd3, v); check("R1 status", v, 8'h00);
    rd(3'd4, v); check("R1 source", v, 8'h00);

    // R2 sensitivity codes on line 0, masked (R5: irq stays high)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); pins[0] = VEC[i][2];
      idle(6);
      wr(3'd1, {6'b0, VEC[i][4:3]});
      wr(3'd3, 8'hFF);
      @(negedge clk); pins[0] = VEC[i][1];
      idle(5);
      rd(3'd3, v); check("R2 status by code", v, {7'b0, VEC[i][0]});
      check("R5 masked irq_n", {7'b0, irq_n}, 8'h01);
    end

    // R9 latency and R5 unmasked source
    @(negedge clk); pins = '0;
    wr(3'd1, 8'h01);
    wr(3'd0, 8'hFE);
    idle(5);
    wr(3'd3, 8'hFF);
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk); @(negedge clk); check("R9 irq after 1 edge", {7'b0, irq_n}, 8'h01);
    @(posedge clk); @(negedge clk); check("R9 irq after 2 edges", {7'b0, irq_n}, 8'h01);
    @(posedge clk); @(negedge clk); check("R9 irq after 3 edges", {7'b0, irq_n}, 8'h00);
    rd(3'd4, v); check("R5 source set", v, 8'h01);

    // R6 masked line 1 records status only
    wr(3'd1, 8'h05);
    @(negedge clk); pins[1] = 1'b1;
    idle(5);
    rd(3'd3, v); check("R6 status", v, 8'h03);
    rd(3'd4, v); check("R6 source", v, 8'h01);

    // R3 write-one-to-clear
    wr(3'd3, 8'h02);
    rd(3'd3, v); check("R3 partial clear status", v, 8'h01);
    check("R4 irq still low", {7'b0, irq_n}, 8'h00);
    wr(3'd3, 8'h01);
    rd(3'd3, v); check("R3 status cleared", v, 8'h00);
    rd(3'd4, v); check("R3 source cleared", v, 8'h00);
    check("R4 irq released", {7'b0, irq_n}, 8'h01);

    // R7 sensitivity change clears
    @(negedge clk); pins[0] = 1'b0; idle(5);
    @(negedge clk); pins[0] = 1'b1; idle(5);
    rd(3'd3, v); check("R7 precondition", v, 8'h01);
    wr(3'd1, 8'h05);
    rd(3'd3, v); check("R7 same code keeps", v, 8'h01);
    wr(3'd1, 8'h07);
    rd(3'd3, v); check("R7 change clears status", v, 8'h00);
    rd(3'd4, v); check("R7 change clears source", v, 8'h00);
    check("R7 irq released", {7'b0, irq_n}, 8'h01);

    // R8 edge and clear in the same cycle
    @(negedge clk); pins[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    wr(3'd3, 8'h01);
    rd(3'd3, v); check("R8 edge wins", v, 8'h01);
    check("R8 irq low", {7'b0, irq_n}, 8'h00);
    wr(3'd3, 8'h01);
    rd(3'd3, v); check("R8 plain clear", v, 8'h00);

    // R10 read map and R2 high register for line 5
    wr(3'd2, 8'h0C);
    rd(3'd2, v); check("R10 sense hi", v, 8'h0C);
    rd(3'd1, v); check("R10 sense lo", v, 8'h07);
    rd(3'd5, v); check("R10 unmapped", v, 8'h00);
    wr(3'd0, 8'hDF);
    @(negedge clk); pins[5] = 1'b1; idle(5);
    rd(3'd4, v); check("R2 high line source", v, 8'h20);
    @(negedge clk); pins[5] = 1'b0; idle(5);
    check("R2 either edge irq", {7'b0, irq_n}, 8'h00);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    check("R1 irq after reset", {7'b0, irq_n}, 8'h01);
    rd(3'd0, v); check("R1 mask after reset", v, 8'hFF);
    rd(3'd3, v); check("R1 status after reset", v, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule